// File: doc/BRIEF.md
# Battery Temperature Zone Charge Governor

This block turns the outputs of a battery thermistor monitor into charge control decisions. It takes four comparator flags (cold, cool, warm and hot) and sorts them into one of five temperature zones. An illegal mix of flags is treated as a sixth, fault zone. From the zone and a few configuration inputs it decides whether to suspend charging, pause the safety timer, reduce the fast-charge current, lower the regulation target, or allow trickle charge.

Two other inputs feed the same decisions. A sensor-open clamp flag is reported as its own status bit, whatever the thermal control enable says. A pushbutton that reads low while charging is active holds charging suspended until it is released. A sticky interrupt records any change of zone or open status, each source with its own mask, and a pulse input clears it. Every output is registered, so a change at the inputs shows at the outputs one clock edge later. The block has an active-low synchronous reset.

Top module: `tzone_governor`

## Requirements
- R1: `zone` takes the zone code one edge after the flags are sampled. The codes are NORMAL=0, COOL=1, COLD=2, WARM=3, HOT=4 and FAULT=5. FAULT wins when a hot-side flag (warm or hot) and a cold-side flag (cool or cold) are both high. Otherwise hot wins over warm and cold wins over cool.
- R2: With `cfg_ctrl_en`=1 and zone COLD, HOT or FAULT, both `chg_suspend` and `tmr_pause` are 1.
- R3: With `cfg_ctrl_en`=1 and zone COOL, `ichg_reduce` is 1 and `trickle_en` stays 1.
- R4: With `cfg_ctrl_en`=1 and zone WARM, `vreg_drop` is 1 (100 mV) when `cfg_vdrop_sel`=0 and 2 (200 mV) when it is 1. In every other case `vreg_drop` is 0.
- R5: With `cfg_ctrl_en`=0, `tmr_pause`, `ichg_reduce` and `vreg_drop` are 0, and `trickle_en` is 1. `zone` and `st_flags` are still reported. `st_flags` bit0 is cold, bit1 cool, bit2 warm and bit3 hot, each the flag registered one edge late.
- R6: Whenever a temperature fault suspends charging (R2), `trickle_en` is 0. In every other case it is 1.
- R7: `chg_suspend` is 1 when `btn_n`=0 and `chg_active`=1 were sampled. It clears on the edge after the button is released, unless R2 holds. The button alone never sets `tmr_pause` and never clears `trickle_en`.
- R8: `st_open` follows `clamp_on` one edge late, whatever the value of `cfg_ctrl_en`.
- R9: `irq` is sticky. It is set by a zone change when `cfg_zone_mask`=0, and by an `st_open` change when `cfg_open_mask`=0. It is cleared by `irq_clr`. When a set and a clear fall on the same edge, the set wins.
- R10: With `rst_n`=0 at an edge, the block returns to zone NORMAL with `st_flags`, `st_open`, `irq`, `chg_suspend`, `tmr_pause`, `ichg_reduce` and `vreg_drop` all 0 and `trickle_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flag_cold | input | 1 | Temperature below the cold threshold |
| flag_cool | input | 1 | Temperature below the cool threshold |
| flag_warm | input | 1 | Temperature above the warm threshold |
| flag_hot | input | 1 | Temperature above the hot threshold |
| clamp_on | input | 1 | Sensor-open clamp active |
| btn_n | input | 1 | Pushbutton level, low when pressed |
| chg_active | input | 1 | Charging in progress |
| cfg_ctrl_en | input | 1 | Enables the zone-based charge actions |
| cfg_vdrop_sel | input | 1 | Warm-zone voltage drop select: 0 is 100 mV, 1 is 200 mV |
| cfg_zone_mask | input | 1 | Masks the zone-change interrupt |
| cfg_open_mask | input | 1 | Masks the open-change interrupt |
| irq_clr | input | 1 | Clears the interrupt |
| zone | output | 3 | Registered zone code |
| st_flags | output | 4 | Registered comparator flags |
| st_open | output | 1 | Sensor-open status |
| chg_suspend | output | 1 | Suspend charging |
| tmr_pause | output | 1 | Pause the charge and safety timers |
| ichg_reduce | output | 1 | Use the reduced fast-charge current |
| vreg_drop | output | 2 | Regulation target drop code |
| trickle_en | output | 1 | Trickle charge allowed |
| irq | output | 1 | Sticky interrupt |

## Verification
Two collisions matter most. The first is an interrupt clear arriving on the same edge as a zone or open change. The bench drives `irq_clr` in the same cycle as a new zone and expects `irq` to stay 1; after a clear pulse with no event it expects 0. The second is a button suspend that overlaps a cold fault. The bench presses the button in a COLD zone and then leaves the zone while holding the button. There it checks that `chg_suspend` stays 1, while `tmr_pause` and `trickle_en` return to their values for the normal zone.

// File: rtl/tzone_pkg.sv
package tzone_pkg;
    localparam int unsigned VDROP_W = 2;
    localparam int unsigned NFLAGS  = 4;

    typedef enum logic [2:0] {
        Z_NORMAL = 3'd0,
        Z_COOL   = 3'd1,
        Z_COLD   = 3'd2,
        Z_WARM   = 3'd3,
        Z_HOT    = 3'd4,
        Z_FAULT  = 3'd5
    } zone_e;

    localparam logic [VDROP_W-1:0] VD_NONE  = VDROP_W'(0);
    localparam logic [VDROP_W-1:0] VD_SMALL = VDROP_W'(1);
    localparam logic [VDROP_W-1:0] VD_LARGE = VDROP_W'(2);

    typedef struct packed {
        zone_e               zone;
        logic [NFLAGS-1:0]   flags;
        logic                open;
        logic                susp;
        logic                pause;
        logic                ich;
        logic [VDROP_W-1:0]  vdrop;
        logic                trk;
        logic                irq;
    } gov_state_t;
endpackage

// File: rtl/tzone_classify.sv
module tzone_classify
    import tzone_pkg::*;
(
    input  logic [NFLAGS-1:0] flags,
    output zone_e             zone
);
    logic hot_side, cold_side;

    always_comb begin
        hot_side  = flags[3] | flags[2];
        cold_side = flags[1] | flags[0];
        if (hot_side && cold_side) zone = Z_FAULT;
        else if (flags[3])         zone = Z_HOT;
        else if (flags[2])         zone = Z_WARM;
        else if (flags[0])         zone = Z_COLD;
        else if (flags[1])         zone = Z_COOL;
        else                       zone = Z_NORMAL;
    end
endmodule

// File: rtl/tzone_action.sv
module tzone_action
    import tzone_pkg::*;
(
    input  zone_e              zone,
    input  logic               ctrl_en,
    input  logic               vdrop_sel,
    input  logic               btn_n,
    input  logic               chg_active,
    output logic               susp,
    output logic               pause,
    output logic               ich,
    output logic [VDROP_W-1:0] vdrop,
    output logic               trk
);
    logic temp_fault, btn_hold;

    always_comb begin
        temp_fault = ctrl_en && (zone == Z_COLD || zone == Z_HOT || zone == Z_FAULT);
        btn_hold   = chg_active && !btn_n;
        susp       = temp_fault || btn_hold;
        pause      = temp_fault;
        trk        = !temp_fault;
        ich        = ctrl_en && (zone == Z_COOL);
        if (ctrl_en && zone == Z_WARM) vdrop = vdrop_sel ? VD_LARGE : VD_SMALL;
        else                           vdrop = VD_NONE;
    end
endmodule

// File: rtl/tzone_governor.sv
module tzone_governor
    import tzone_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flag_cold,
    input  logic        flag_cool,
    input  logic        flag_warm,
    input  logic        flag_hot,
    input  logic        clamp_on,
    input  logic        btn_n,
    input  logic        chg_active,
    input  logic        cfg_ctrl_en,
    input  logic        cfg_vdrop_sel,
    input  logic        cfg_zone_mask,
    input  logic        cfg_open_mask,
    input  logic        irq_clr,
    output logic [2:0]  zone,
    output logic [3:0]  st_flags,
    output logic        st_open,
    output logic        chg_suspend,
    output logic        tmr_pause,
    output logic        ichg_reduce,
    output logic [1:0]  vreg_drop,
    output logic        trickle_en,
    output logic        irq
);
    gov_state_t         state_d, state_q;
    logic [NFLAGS-1:0]  flags_in;
    zone_e              zone_n;
    logic               susp_n, pause_n, ich_n, trk_n;
    logic [VDROP_W-1:0] vdrop_n;
    logic               ev_zone, ev_open;

    assign flags_in = {flag_hot, flag_warm, flag_cool, flag_cold};

    tzone_classify u_classify (
        .flags (flags_in),
        .zone  (zone_n)
    );

    tzone_action u_action (
        .zone       (zone_n),
        .ctrl_en    (cfg_ctrl_en),
        .vdrop_sel  (cfg_vdrop_sel),
        .btn_n      (btn_n),
        .chg_active (chg_active),
        .susp       (susp_n),
        .pause      (pause_n),
        .ich        (ich_n),
        .vdrop      (vdrop_n),
        .trk        (trk_n)
    );

    always_comb begin
        ev_zone       = (zone_n != state_q.zone) && !cfg_zone_mask;
        ev_open       = (clamp_on != state_q.open) && !cfg_open_mask;
        state_d       = state_q;
        state_d.zone  = zone_n;
        state_d.flags = flags_in;
        state_d.open  = clamp_on;
        state_d.susp  = susp_n;
        state_d.pause = pause_n;
        state_d.ich   = ich_n;
        state_d.vdrop = vdrop_n;
        state_d.trk   = trk_n;
        if (ev_zone || ev_open) state_d.irq = 1'b1;
        else if (irq_clr)       state_d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.zone <= Z_NORMAL;
            state_q.trk  <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign zone        = state_q.zone;
    assign st_flags    = state_q.flags;
    assign st_open     = state_q.open;
    assign chg_suspend = state_q.susp;
    assign tmr_pause   = state_q.pause;
    assign ichg_reduce = state_q.ich;
    assign vreg_drop   = state_q.vdrop;
    assign trickle_en  = state_q.trk;
    assign irq         = state_q.irq;
endmodule

// File: rtl/tzone_governor_chk.sv
module tzone_governor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clamp_on,
    input logic       cfg_ctrl_en,
    input logic       irq_clr,
    input logic [2:0] zone,
    input logic       st_open,
    input logic       chg_suspend,
    input logic       tmr_pause,
    input logic       ichg_reduce,
    input logic [1:0] vreg_drop,
    input logic       trickle_en,
    input logic       irq
);
    a_r2_pause_implies_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_pause |-> chg_suspend);
    a_r6_trickle_off_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_pause |-> !trickle_en);
    a_r3_cool_keeps_trickle: assert property (@(posedge clk) disable iff (!rst_n)
        ichg_reduce |-> (trickle_en && zone == 3'd1));
    a_r4_drop_only_warm: assert property (@(posedge clk) disable iff (!rst_n)
        (vreg_drop != 2'd0) |-> (zone == 3'd3));
    a_r5_off_no_action: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ctrl_en |=> (vreg_drop == 2'd0 && !ichg_reduce && !tmr_pause && trickle_en));
    a_r8_open_tracks_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_on |=> st_open);
    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
endmodule

bind tzone_governor tzone_governor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clamp_on    (clamp_on),
    .cfg_ctrl_en (cfg_ctrl_en),
    .irq_clr     (irq_clr),
    .zone        (zone),
    .st_open     (st_open),
    .chg_suspend (chg_suspend),
    .tmr_pause   (tmr_pause),
    .ichg_reduce (ichg_reduce),
    .vreg_drop   (vreg_drop),
    .trickle_en  (trickle_en),
    .irq         (irq)
);

// File: tb/tzone_governor_tb_top.sv
module tzone_governor_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic f_cold = 0, f_cool = 0, f_warm = 0, f_hot = 0;
    logic clamp = 0, btn_n = 1, chg_act = 0;
    logic en = 1, vsel = 0, zmask = 0, omask = 0, clr = 0;
    logic [2:0] zone;
    logic [3:0] st_flags;
    logic st_open, chg_suspend, tmr_pause, ichg_reduce, trickle_en, irq;
    logic [1:0] vreg_drop;

    int vectors = 0;
    int errors = 0;

    int m_zone = 0, m_flags = 0, m_open = 0, m_susp = 0, m_pause = 0;
    int m_ich = 0, m_vd = 0, m_trk = 1, m_irq = 0;

    tzone_governor dut_i (
        .clk(clk), .rst_n(rst_n),
        .flag_cold(f_cold), .flag_cool(f_cool), .flag_warm(f_warm), .flag_hot(f_hot),
        .clamp_on(clamp), .btn_n(btn_n), .chg_active(chg_act),
        .cfg_ctrl_en(en), .cfg_vdrop_sel(vsel), .cfg_zone_mask(zmask),
        .cfg_open_mask(omask), .irq_clr(clr),
        .zone(zone), .st_flags(st_flags), .st_open(st_open),
        .chg_suspend(chg_suspend), .tmr_pause(tmr_pause), .ichg_reduce(ichg_reduce),
        .vreg_drop(vreg_drop), .trickle_en(trickle_en), .irq(irq)
    );

    // Behavioural reference: what the requirements say the outputs become after one edge.
    task automatic model_edge();
        int nz;
        bit fault;
        if (!rst_n) begin
            m_zone = 0; m_flags = 0; m_open = 0; m_susp = 0; m_pause = 0;
            m_ich = 0; m_vd = 0; m_trk = 1; m_irq = 0;
            return;
        end
        if ((f_hot || f_warm) && (f_cold || f_cool)) nz = 5;
        else if (f_hot)  nz = 4;
        else if (f_warm) nz = 3;
        else if (f_cold) nz = 2;
        else if (f_cool) nz = 1;
        else             nz = 0;
        fault = en && (nz == 2 || nz == 4 || nz == 5);
        if ((nz != m_zone && !zmask) || (int'(clamp) != m_open && !omask)) m_irq = 1;
        else if (clr) m_irq = 0;
        m_zone  = nz;
        m_flags = {f_hot, f_warm, f_cool, f_cold};
        m_open  = clamp;
        m_pause = fault;
        m_susp  = fault || (chg_act && !btn_n);
        m_trk   = !fault;
        m_ich   = en && nz == 1;
        m_vd    = (en && nz == 3) ? (vsel ? 2 : 1) : 0;
    endtask

    function automatic void chk(string tag, int act, int exp);
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endfunction

    task automatic compare_all(string rst_tag);
        vectors++;
        chk({"R1 zone ", rst_tag}, zone, m_zone);
        chk({"R5 st_flags ", rst_tag}, st_flags, m_flags);
        chk({"R8 st_open ", rst_tag}, st_open, m_open);
        chk({"R2/R7 chg_suspend ", rst_tag}, chg_suspend, m_susp);
        chk({"R2 tmr_pause ", rst_tag}, tmr_pause, m_pause);
        chk({"R3 ichg_reduce ", rst_tag}, ichg_reduce, m_ich);
        chk({"R4 vreg_drop ", rst_tag}, vreg_drop, m_vd);
        chk({"R6 trickle_en ", rst_tag}, trickle_en, m_trk);
        chk({"R9 irq ", rst_tag}, irq, m_irq);
    endtask

    task automatic step(string tag = "");
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic temp(bit h, bit w, bit co, bit c);
        f_hot = h; f_warm = w; f_cool = co; f_cold = c;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R10: reset state
        rst_n = 0; temp(1, 0, 0, 1); clamp = 1;
        step("R10"); step("R10");
        temp(0, 0, 0, 0); clamp = 0; rst_n = 1;
        step();
        // R1, R3: cool zone, trickle kept
        temp(0, 0, 1, 0); step();
        // R2, R6: cold zone
        temp(0, 0, 1, 1); step();
        clr = 1; step(); clr = 0;                 // R9 clear
        // R4: warm, both drop sizes
        temp(0, 1, 0, 0); vsel = 0; step();
        vsel = 1; step();
        // R1: hot over warm
        temp(1, 1, 0, 0); step();
        // R1: illegal mixes give FAULT
        temp(1, 0, 0, 1); step();
        temp(0, 1, 1, 0); step();
        // R9: clear on the same edge as a zone change, set wins
        clr = 1; temp(0, 0, 0, 0); step(); clr = 0;
        clr = 1; step(); clr = 0;
        // R5: enable off, faults still reported
        en = 0;
        temp(0, 0, 0, 1); step();
        temp(0, 1, 0, 0); step();
        temp(0, 0, 1, 0); step();
        // R8: open status with enable off, and open mask
        clamp = 1; step();
        clr = 1; step(); clr = 0;
        omask = 1; clamp = 0; step();
        omask = 0; en = 1;
        // R9: zone mask
        zmask = 1; clr = 1; temp(1, 0, 0, 0); step(); clr = 0;
        temp(0, 0, 0, 0); step();
        zmask = 0;
        // R7: button while charging, and without charging
        chg_act = 1; btn_n = 0; step();
        btn_n = 1; step();
        chg_act = 0; btn_n = 0; step();
        // R7: button overlapping a cold fault, then leaving the zone
        chg_act = 1; temp(0, 0, 0, 1); step();
        temp(0, 0, 0, 0); step();
        btn_n = 1; step();
        // mixed sweep of every flag pattern under both enables
        for (int e = 0; e < 2; e++) begin
            for (int p = 0; p < 16; p++) begin
                en = e[0]; temp(p[3], p[2], p[1], p[0]);
                vsel = p[0]; clamp = p[1] ^ p[3]; clr = p[2];
                step();
            end
        end
        clr = 0;
        // R10: reset in mid-run
        temp(1, 0, 0, 0); step();
        rst_n = 0; step("R10");
        rst_n = 1; temp(0, 0, 0, 0); step();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule